// File: doc/BRIEF.md
# Scan-Driven Flash Command Register

This block is a test-access-port data register that carries flash programming commands in from the scan path. It is selected only while the instruction register holds the programming-command opcode. The TAP controller supplies level strobes that show which controller state the current TCK cycle is in: capture, shift, update, run-test/idle, or test-logic-reset. The block also receives TDI and drives TDO. On the flash side it drives a command word, a one-cycle apply strobe and a one-cycle execute pulse, and it reads back a result word.

Capture loads the result of the previous command into the shift register. Each scan therefore shifts the old result out and the next command in during the same pass. Update only places the new command on the command outputs. The execute pulse comes on the first run-test/idle cycle after that update.

A small sequencer sets the flash-side timing, using four named states:
- ST_IDLE: no command pending. Update moves it to ST_APPLY.
- ST_APPLY: the apply strobe is high. Update stays in ST_APPLY, run-test/idle moves it to ST_FIRE, and anything else moves it to ST_LOADED.
- ST_LOADED: the command is applied and waiting. Update moves it to ST_APPLY and run-test/idle moves it to ST_FIRE.
- ST_FIRE: the execute pulse is high. Update moves it to ST_APPLY and anything else moves it to ST_IDLE.

Test-logic-reset forces the sequencer to ST_IDLE from any state.

Top module: `tap_flash_cmd_reg`

## Requirements
- R1: The register responds only while `ir_code` equals 4'h5. With any other code, every strobe is ignored, `tdo` is 0, and no apply strobe or execute pulse occurs.
- R2: The scan path between TDI and the command output is exactly 15 bits long. After N shifts with N > 15, `cmd_o` holds the last 15 bits shifted in.
- R3: On a capture cycle, the shift register loads `result_i`.
- R4: Shifting is LSB first. `tdo` shows bit 0 of the shift register, and each shift cycle moves the register one place toward bit 0 while `tdi` enters at bit 14.
- R5: An update cycle copies the shift register to `cmd_o`. `cmd_apply` is high for exactly the one cycle that follows that edge.
- R6: `cmd_o` does not change except on an update cycle or a test-logic-reset.
- R7: `exec_pulse` is high for one cycle after the first run-test/idle cycle that follows an update. Further run-test/idle cycles produce no pulse until the next update.
- R8: Test-logic-reset clears `cmd_o`, clears the shift register and cancels any pending execute.
- R9: After the asynchronous reset, `cmd_o` is 0 and `cmd_apply`, `exec_pulse` and `tdo` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_code | input | 4 | Current instruction register value |
| tlr | input | 1 | Controller is in test-logic-reset |
| capture_dr | input | 1 | Controller is in Capture-DR |
| shift_dr | input | 1 | Controller is in Shift-DR |
| update_dr | input | 1 | Controller is in Update-DR |
| run_idle | input | 1 | Controller is in Run-Test/Idle |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (bit 0 of the shift register) |
| result_i | input | 15 | Result of the last executed command |
| cmd_o | output | 15 | Applied command word |
| cmd_apply | output | 1 | One-cycle strobe after the command is updated |
| exec_pulse | output | 1 | One-cycle execute clock |

## Verification
The bench sends a sweep of command words through a flash model whose result is a fixed rotate-and-XOR of the executed command. The sweep covers all-zeros, all-ones, every walking-one position and a set of arithmetic patterns. The walking ones show up any bit-order or off-by-one fault in the serial path. The rotate-and-XOR result confirms that each scan returns the previous command's result and not the current one. A 16-bit overshift checks the 15-bit length. Scans with a foreign opcode, run-test/idle with no update, and test-logic-reset in the middle of the flow check that nothing is applied or executed that should not be.

// File: rtl/tfc_pkg.sv
package tfc_pkg;
    localparam int unsigned CMD_W_DEF  = 15;
    localparam int unsigned IR_W_DEF   = 4;
    localparam logic [3:0]  OPCODE_DEF = 4'h5;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_APPLY  = 2'd1,
        ST_LOADED = 2'd2,
        ST_FIRE   = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic clr;
        logic cap;
        logic shf;
        logic upd;
        logic rti;
    } dr_strobe_t;
endpackage

// File: rtl/tfc_decode.sv
module tfc_decode
    import tfc_pkg::*;
#(
    parameter int unsigned IR_W   = IR_W_DEF,
    parameter logic [IR_W-1:0] OPCODE = OPCODE_DEF
) (
    input  logic [IR_W-1:0] ir_code,
    input  logic            tlr,
    input  logic            capture_dr,
    input  logic            shift_dr,
    input  logic            update_dr,
    input  logic            run_idle,
    output logic            sel,
    output dr_strobe_t      stb
);
    // Test-logic-reset wins over all others; then capture, shift, update.
    always_comb begin
        sel     = (ir_code == OPCODE);
        stb.clr = tlr;
        stb.cap = sel && !tlr && capture_dr;
        stb.shf = sel && !tlr && !capture_dr && shift_dr;
        stb.upd = sel && !tlr && !capture_dr && !shift_dr && update_dr;
        stb.rti = sel && !tlr && run_idle;
    end
endmodule

// File: rtl/tfc_shifter.sv
module tfc_shifter #(
    parameter int unsigned CMD_W = 15
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             cap,
    input  logic             shf,
    input  logic             tdi,
    input  logic [CMD_W-1:0] par_in,
    output logic [CMD_W-1:0] sr_q
);
    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (clr) begin
            sr_q <= '0;
        end else if (cap) begin
            sr_q <= par_in;
        end else if (shf) begin
            sr_q <= {tdi, sr_q[CMD_W-1:1]};
        end
    end
endmodule

// File: rtl/tfc_cmd_hold.sv
module tfc_cmd_hold #(
    parameter int unsigned CMD_W = 15
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [CMD_W-1:0] d,
    output logic [CMD_W-1:0] q
);
    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/tfc_seq.sv
module tfc_seq
    import tfc_pkg::*;
(
    input  logic tck,
    input  logic rst_n,
    input  logic clr,
    input  logic upd,
    input  logic rti,
    output logic apply,
    output logic exec
);
    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (upd) state_d = ST_APPLY;
            end
            ST_APPLY: begin
                if (upd)      state_d = ST_APPLY;
                else if (rti) state_d = ST_FIRE;
                else          state_d = ST_LOADED;
            end
            ST_LOADED: begin
                if (upd)      state_d = ST_APPLY;
                else if (rti) state_d = ST_FIRE;
            end
            ST_FIRE: begin
                if (upd) state_d = ST_APPLY;
                else     state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        if (clr) state_d = ST_IDLE;
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        apply = 1'b0;
        exec  = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_APPLY:  apply = 1'b1;
            ST_LOADED: ;
            ST_FIRE:   exec = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/tap_flash_cmd_reg.sv
module tap_flash_cmd_reg
    import tfc_pkg::*;
#(
    parameter int unsigned CMD_W = CMD_W_DEF,
    parameter int unsigned IR_W  = IR_W_DEF,
    parameter logic [IR_W-1:0] OPCODE = OPCODE_DEF
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic [IR_W-1:0]  ir_code,
    input  logic             tlr,
    input  logic             capture_dr,
    input  logic             shift_dr,
    input  logic             update_dr,
    input  logic             run_idle,
    input  logic             tdi,
    output logic             tdo,
    input  logic [CMD_W-1:0] result_i,
    output logic [CMD_W-1:0] cmd_o,
    output logic             cmd_apply,
    output logic             exec_pulse
);
    logic             sel;
    dr_strobe_t       stb;
    logic [CMD_W-1:0] sr_q;

    tfc_decode #(.IR_W(IR_W), .OPCODE(OPCODE)) u_dec (
        .ir_code(ir_code), .tlr(tlr), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .run_idle(run_idle),
        .sel(sel), .stb(stb)
    );

    tfc_shifter #(.CMD_W(CMD_W)) u_sr (
        .tck(tck), .rst_n(rst_n), .clr(stb.clr), .cap(stb.cap),
        .shf(stb.shf), .tdi(tdi), .par_in(result_i), .sr_q(sr_q)
    );

    tfc_cmd_hold #(.CMD_W(CMD_W)) u_hold (
        .tck(tck), .rst_n(rst_n), .clr(stb.clr), .load(stb.upd),
        .d(sr_q), .q(cmd_o)
    );

    tfc_seq u_seq (
        .tck(tck), .rst_n(rst_n), .clr(stb.clr), .upd(stb.upd),
        .rti(stb.rti), .apply(cmd_apply), .exec(exec_pulse)
    );

    assign tdo = sel ? sr_q[0] : 1'b0;
endmodule

// File: rtl/tfc_checker.sv
module tfc_checker #(
    parameter int unsigned CMD_W = 15,
    parameter int unsigned IR_W  = 4,
    parameter logic [IR_W-1:0] OPCODE = 4'h5
) (
    input logic             tck,
    input logic             rst_n,
    input logic [IR_W-1:0]  ir_code,
    input logic             tlr,
    input logic             capture_dr,
    input logic             shift_dr,
    input logic             update_dr,
    input logic             tdo,
    input logic [CMD_W-1:0] cmd_o,
    input logic             cmd_apply,
    input logic             exec_pulse
);
    AST_FOREIGN_QUIET: assert property (@(posedge tck) disable iff (!rst_n)
        (ir_code != OPCODE) |=> (!cmd_apply && !exec_pulse)); // R1
    AST_FOREIGN_TDO: assert property (@(posedge tck) disable iff (!rst_n)
        (ir_code != OPCODE) |-> !tdo); // R1
    AST_APPLY_FOLLOWS: assert property (@(posedge tck) disable iff (!rst_n)
        (ir_code == OPCODE && update_dr && !tlr && !capture_dr && !shift_dr) |=> cmd_apply); // R5
    AST_APPLY_SINGLE: assert property (@(posedge tck) disable iff (!rst_n)
        (cmd_apply && !update_dr) |=> !cmd_apply); // R5
    AST_CMD_HELD: assert property (@(posedge tck) disable iff (!rst_n)
        (!update_dr && !tlr) |=> $stable(cmd_o)); // R6
    AST_EXEC_SINGLE: assert property (@(posedge tck) disable iff (!rst_n)
        exec_pulse |=> !exec_pulse); // R7
    AST_STROBES_EXCL: assert property (@(posedge tck) disable iff (!rst_n)
        $onehot0({cmd_apply, exec_pulse})); // R7
    AST_TLR_CLEARS: assert property (@(posedge tck) disable iff (!rst_n)
        tlr |=> (cmd_o == '0 && !cmd_apply && !exec_pulse)); // R8
endmodule

bind tap_flash_cmd_reg tfc_checker #(.CMD_W(CMD_W), .IR_W(IR_W), .OPCODE(OPCODE)) u_chk (
    .tck(tck), .rst_n(rst_n), .ir_code(ir_code), .tlr(tlr),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .tdo(tdo), .cmd_o(cmd_o), .cmd_apply(cmd_apply), .exec_pulse(exec_pulse)
);

// File: tb/sim_tap_flash_cmd_reg.sv
`timescale 1ns/1ps
module sim_tap_flash_cmd_reg;
    logic        tck = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ir_code = 4'h5;
    logic        tlr = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0;
    logic        update_dr = 1'b0, run_idle = 1'b0, tdi = 1'b0;
    logic        tdo, cmd_apply, exec_pulse;
    logic [14:0] result_i, cmd_o;
    logic [14:0] model_res = '0;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #2.5 tck = ~tck;

    tap_flash_cmd_reg u0 (
        .tck(tck), .rst_n(rst_n), .ir_code(ir_code), .tlr(tlr),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .run_idle(run_idle), .tdi(tdi), .tdo(tdo), .result_i(result_i),
        .cmd_o(cmd_o), .cmd_apply(cmd_apply), .exec_pulse(exec_pulse)
    );

    // Flash model: result is a rotate-left-by-3 of the command XOR a constant.
    function automatic logic [14:0] fmodel(input logic [14:0] c);
        return {c[11:0], c[14:12]} ^ 15'h2C71;
    endfunction

    always @(posedge tck) if (exec_pulse) model_res <= fmodel(cmd_o);
    assign result_i = model_res;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge tck);
        @(negedge tck);
    endtask

    // Capture, shift nb bits of data, update. Returns the tdo bits seen.
    task automatic scan(input logic [15:0] data, input int nb, output logic [15:0] got);
        got = '0;
        capture_dr = 1'b1; tick(); capture_dr = 1'b0;
        for (int i = 0; i < nb; i++) begin
            shift_dr = 1'b1; tdi = data[i];
            got[i] = tdo;
            tick();
        end
        shift_dr = 1'b0; tdi = 1'b0;
        update_dr = 1'b1; tick(); update_dr = 1'b0;
    endtask

    // Hold run-test/idle for n cycles; returns number of exec pulses seen.
    task automatic idle_run(input int n, output int pulses, output logic first);
        pulses = 0;
        first = 1'b0;
        run_idle = 1'b1;
        for (int k = 0; k < n; k++) begin
            tick();
            if (k == 0) first = exec_pulse;
            if (exec_pulse) pulses++;
        end
        run_idle = 1'b0;
    endtask

    initial begin
        logic [14:0] exp_res, cmd, held;
        logic [15:0] got;
        int          np;
        logic        first;
        exp_res = '0;
        repeat (3) @(negedge tck);
        chk("R9 cmd_o", cmd_o, 0);
        chk("R9 apply", cmd_apply, 0);
        chk("R9 exec", exec_pulse, 0);
        chk("R9 tdo", tdo, 0);
        rst_n = 1'b1;
        tick();

        // Main sweep: zeros, ones, walking ones, arithmetic patterns
        for (int n = 0; n < 40; n++) begin
            if (n == 0)      cmd = 15'h0000;
            else if (n == 1) cmd = 15'h7FFF;
            else if (n < 17) cmd = 15'(1 << (n - 2));
            else             cmd = 15'(n * 32'h0A31 + n * n * 7);
            scan({1'b0, cmd}, 15, got);
            chk("R3 R4 previous result out", got[14:0], exp_res);
            chk("R5 cmd_o after update", cmd_o, cmd);
            chk("R5 apply", cmd_apply, 1);
            idle_run(3, np, first);
            chk("R7 exec on first idle", first, 1);
            chk("R7 single exec", np, 1);
            chk("R5 apply cleared", cmd_apply, 0);
            chk("R6 cmd_o held", cmd_o, cmd);
            exp_res = fmodel(cmd);
        end

        // R2: 16-bit overshift keeps the last 15 bits
        scan(16'hB5C3, 16, got);
        chk("R2 overshift cmd_o", cmd_o, 32'(16'hB5C3 >> 1));
        chk("R2 overshift old result", got[14:0], exp_res);
        idle_run(2, np, first);
        chk("R7 exec overshift", np, 1);
        held = 15'(16'hB5C3 >> 1);
        exp_res = fmodel(held);

        // R1: foreign opcode scan ignored
        ir_code = 4'h3;
        scan(16'h1234, 15, got);
        chk("R1 tdo zero", got[14:0], 0);
        chk("R1 cmd_o unchanged", cmd_o, held);
        chk("R1 no apply", cmd_apply, 0);
        idle_run(2, np, first);
        chk("R1 no exec", np, 0);
        ir_code = 4'h5;
        // Update-only shows the shift register kept the last selected word
        update_dr = 1'b1; tick(); update_dr = 1'b0;
        chk("R1 shift reg untouched", cmd_o, held);
        idle_run(2, np, first);
        chk("R7 exec after update-only", np, 1);

        // R7: idle without update gives no pulse
        idle_run(4, np, first);
        chk("R7 no exec without update", np, 0);

        // R8: test-logic-reset clears and cancels pending execute
        scan(16'h2AAA, 15, got);
        chk("R8 setup cmd", cmd_o, 15'h2AAA);
        tlr = 1'b1; tick(); tlr = 1'b0;
        chk("R8 cmd cleared", cmd_o, 0);
        idle_run(3, np, first);
        chk("R8 pending cancelled", np, 0);
        update_dr = 1'b1; tick(); update_dr = 1'b0;
        chk("R8 shift reg cleared", cmd_o, 0);
        idle_run(2, np, first);
        exp_res = fmodel(15'h0);
        scan(16'h0001, 15, got);
        chk("R3 result after clear", got[14:0], exp_res);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule